// File: doc/BRIEF.md
# Barrel Thread Issue Selector

This block chooses, on every clock cycle, which hardware thread context may issue its next instruction. Contexts are visited in rotating order. The search for each cycle starts one place after the context that issued last, so a context that has just issued has the lowest priority. Any context that is not able to issue is skipped. The result is a registered context number with a valid strobe. The instruction pipeline uses it to fetch and issue from that context in the following cycle.

A context can issue when three things hold: the pipeline marks it valid, the pipeline marks it ready, and it has not used up its memory independence budget. Every memory operation carries a lookahead count. This count says how many later instructions of the same thread do not depend on that operation. When a memory operation is reported as issued, the context loads the count into its budget. Each later grant to that context uses up one unit of budget. Once the budget is empty and the operation is still in flight, the context is held back. A completion report for the context releases it.

The number of contexts is a parameter, from 2 up to 128. The width of the lookahead field is also a parameter. Decode, register state and the memory system sit outside this block.

Top module: `barrel_issue_sched`

## Requirements
- R1: After synchronous reset `rst`, `grant_valid` and `grant_ctx` read 0. No context has a memory operation in flight. The search pointer is 0, so the first grant goes to the lowest-numbered context that can issue.
- R2: The grant is registered. A grant computed from the inputs and state of cycle t appears on `grant_valid`/`grant_ctx` after the clock edge that ends cycle t. At most one context is granted per cycle.
- R3: A context is granted only if its `ctx_valid` bit is 1, its `ctx_ready` bit is 1, and it is not held back by an empty budget.
- R4: The search starts at the pointer and wraps from NCTX-1 to 0. After a grant to context c, the pointer becomes c+1, or 0 when c is NCTX-1.
- R5: When no context can issue, `grant_valid` is 0 in the next cycle and the pointer keeps its value.
- R6: When `mem_iss_en` is 1, the context `mem_iss_ctx` marks an operation in flight and loads its budget with `mem_iss_look`. Each later grant to that context while the operation is in flight and the budget is non-zero lowers the budget by 1. A context with an operation in flight and a budget of 0 is held back.
- R7: When `mem_done_en` is 1, the context `mem_done_ctx` no longer has an operation in flight and can be granted again. If an issue and a completion name the same context in the same cycle, the issue wins.
- R8: A lookahead of 0 holds the context back from the cycle after the issue report until a completion arrives.
- R9: `grant_ctx` is $clog2(NCTX) bits wide, and while `grant_valid` is 1 it is always below NCTX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctx_valid | input | NCTX | Context holds a live thread, one bit per context |
| ctx_ready | input | NCTX | Context has an instruction ready, one bit per context |
| mem_iss_en | input | 1 | A memory operation was issued |
| mem_iss_ctx | input | IDW | Context of the issued memory operation |
| mem_iss_look | input | LA_W | Lookahead count carried by that operation |
| mem_done_en | input | 1 | A memory operation completed |
| mem_done_ctx | input | IDW | Context of the completed operation |
| grant_valid | output | 1 | A context is selected this cycle |
| grant_ctx | output | IDW | Selected context number |

## Verification
Each grant reflects the inputs and state of the previous cycle. The bench therefore drives its inputs just after a falling edge and compares the outputs at the next falling edge, once the single rising edge between them has registered the result. Issue and completion reports update the budget state at that same edge, so their effect on eligibility shows up in the grant one cycle later. The bench model applies each update in the same step in which it predicts the grant, which keeps both delays aligned. Directed sequences cover a lookahead of 0, budget exhaustion, release by completion, wrap-around and an idle pointer hold. A long random phase exercises all of these together.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

    localparam int MAX_CTX = 128;

    // slot that follows cur in a ring of n entries
    function automatic int ring_next(input int cur, input int n);
        return (cur >= n - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/bsched_ctx_budget.sv
module bsched_ctx_budget #(
    parameter int NCTX = 8,
    parameter int LA_W = 3,
    parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_en,
    input  logic [IDW-1:0]  iss_ctx,
    input  logic [LA_W-1:0] iss_look,
    input  logic            done_en,
    input  logic [IDW-1:0]  done_ctx,
    input  logic            gnt_en,
    input  logic [IDW-1:0]  gnt_ctx,
    output logic [NCTX-1:0] held
);

    typedef struct packed {
        logic            busy;
        logic [LA_W-1:0] left;
    } slot_t;

    for (genvar g = 0; g < NCTX; g++) begin : g_slot
        localparam logic [IDW-1:0] MY_ID = IDW'(g);
        slot_t s_d;
        slot_t s_q;

        always_comb begin
            s_d = s_q;
            if (iss_en && iss_ctx == MY_ID) begin
                s_d.busy = 1'b1;
                s_d.left = iss_look;
            end else if (done_en && done_ctx == MY_ID) begin
                s_d.busy = 1'b0;
                s_d.left = '0;
            end else if (gnt_en && gnt_ctx == MY_ID && s_q.busy && s_q.left != '0) begin
                s_d.left = s_q.left - 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) s_q <= '0;
            else     s_q <= s_d;
        end

        assign held[g] = s_q.busy && (s_q.left == '0);
    end

endmodule

// File: rtl/bsched_rr_pick.sv
module bsched_rr_pick #(
    parameter int NCTX = 8,
    parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [NCTX-1:0] open_mask,
    input  logic [IDW-1:0]  start,
    output logic            hit,
    output logic [IDW-1:0]  pick
);

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 0; k < NCTX; k++) begin
            int pos;
            pos = int'(start) + k;
            if (pos >= NCTX) pos = pos - NCTX;
            if (!hit && open_mask[pos]) begin
                hit  = 1'b1;
                pick = IDW'(pos);
            end
        end
    end

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched #(
    parameter int NCTX = 8,
    parameter int LA_W = 3,
    parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NCTX-1:0] ctx_valid,
    input  logic [NCTX-1:0] ctx_ready,
    input  logic            mem_iss_en,
    input  logic [IDW-1:0]  mem_iss_ctx,
    input  logic [LA_W-1:0] mem_iss_look,
    input  logic            mem_done_en,
    input  logic [IDW-1:0]  mem_done_ctx,
    output logic            grant_valid,
    output logic [IDW-1:0]  grant_ctx
);

    typedef struct packed {
        logic [IDW-1:0] ptr;
        logic           gv;
        logic [IDW-1:0] gid;
    } sel_t;

    sel_t            st_d;
    sel_t            st_q;
    logic [NCTX-1:0] ctx_held;
    logic [NCTX-1:0] ctx_open;
    logic            pick_hit;
    logic [IDW-1:0]  pick_ctx;
    logic [IDW-1:0]  rr_ptr;

    assign ctx_open = ctx_valid & ctx_ready & ~ctx_held;
    assign rr_ptr   = st_q.ptr;

    bsched_ctx_budget #(.NCTX(NCTX), .LA_W(LA_W), .IDW(IDW)) budget_i (
        .clk      (clk),
        .rst      (rst),
        .iss_en   (mem_iss_en),
        .iss_ctx  (mem_iss_ctx),
        .iss_look (mem_iss_look),
        .done_en  (mem_done_en),
        .done_ctx (mem_done_ctx),
        .gnt_en   (pick_hit),
        .gnt_ctx  (pick_ctx),
        .held     (ctx_held)
    );

    bsched_rr_pick #(.NCTX(NCTX), .IDW(IDW)) pick_i (
        .open_mask (ctx_open),
        .start     (st_q.ptr),
        .hit       (pick_hit),
        .pick      (pick_ctx)
    );

    always_comb begin
        st_d    = st_q;
        st_d.gv = pick_hit;
        if (pick_hit) begin
            st_d.gid = pick_ctx;
            st_d.ptr = IDW'(bsched_pkg::ring_next(int'(pick_ctx), NCTX));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign grant_valid = st_q.gv;
    assign grant_ctx   = st_q.gid;

endmodule

// File: rtl/barrel_issue_sched_chk.sv
module barrel_issue_sched_chk #(
    parameter int NCTX = 8,
    parameter int IDW  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [NCTX-1:0] ctx_valid,
    input logic [NCTX-1:0] ctx_ready,
    input logic [NCTX-1:0] ctx_held,
    input logic            grant_valid,
    input logic [IDW-1:0]  grant_ctx,
    input logic [IDW-1:0]  rr_ptr
);

    logic [NCTX-1:0] open_prev;

    always_ff @(posedge clk) begin
        if (rst) open_prev <= '0;
        else     open_prev <= ctx_valid & ctx_ready & ~ctx_held;
    end

    AST_GRANT_OPEN: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> open_prev[grant_ctx]); // R3

    AST_IDLE_NONE_OPEN: assert property (@(posedge clk) disable iff (rst)
        !grant_valid |-> (open_prev == '0)); // R5

    AST_PTR_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (int'(rr_ptr) == ((int'(grant_ctx) == NCTX - 1) ? 0 : int'(grant_ctx) + 1))); // R4

    AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !grant_valid |-> $stable(rr_ptr)); // R5

endmodule

bind barrel_issue_sched barrel_issue_sched_chk #(.NCTX(NCTX), .IDW(IDW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ctx_valid   (ctx_valid),
    .ctx_ready   (ctx_ready),
    .ctx_held    (ctx_held),
    .grant_valid (grant_valid),
    .grant_ctx   (grant_ctx),
    .rr_ptr      (rr_ptr)
);

// File: tb/barrel_issue_sched_tb_top.sv
module barrel_issue_sched_tb_top;

    localparam int NCTX = 8;
    localparam int LA_W = 3;
    localparam int IDW  = $clog2(NCTX);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCTX-1:0] ctx_valid = '0;
    logic [NCTX-1:0] ctx_ready = '0;
    logic            mem_iss_en = 1'b0;
    logic [IDW-1:0]  mem_iss_ctx = '0;
    logic [LA_W-1:0] mem_iss_look = '0;
    logic            mem_done_en = 1'b0;
    logic [IDW-1:0]  mem_done_ctx = '0;
    logic            grant_valid;
    logic [IDW-1:0]  grant_ctx;

    int n_cmp = 0;
    int n_bad = 0;

    bit m_busy [NCTX];
    int m_left [NCTX];
    int m_ptr;
    bit exp_v;
    int exp_id;

    always #4 clk = ~clk;

    barrel_issue_sched #(.NCTX(NCTX), .LA_W(LA_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .ctx_valid    (ctx_valid),
        .ctx_ready    (ctx_ready),
        .mem_iss_en   (mem_iss_en),
        .mem_iss_ctx  (mem_iss_ctx),
        .mem_iss_look (mem_iss_look),
        .mem_done_en  (mem_done_en),
        .mem_done_ctx (mem_done_ctx),
        .grant_valid  (grant_valid),
        .grant_ctx    (grant_ctx)
    );

    function automatic bit can_go(input int c);
        return ctx_valid[c] && ctx_ready[c] && !(m_busy[c] && m_left[c] == 0);
    endfunction

    // predict the grant from the driven inputs, then advance the model state
    function automatic void model_step();
        exp_v = 1'b0;
        for (int k = 0; k < NCTX; k++) begin
            int c = (m_ptr + k) % NCTX;
            if (!exp_v && can_go(c)) begin
                exp_v  = 1'b1;
                exp_id = c;
            end
        end
        for (int c = 0; c < NCTX; c++) begin
            if (mem_iss_en && int'(mem_iss_ctx) == c) begin
                m_busy[c] = 1'b1;
                m_left[c] = int'(mem_iss_look);
            end else if (mem_done_en && int'(mem_done_ctx) == c) begin
                m_busy[c] = 1'b0;
                m_left[c] = 0;
            end else if (exp_v && exp_id == c && m_busy[c] && m_left[c] > 0) begin
                m_left[c] = m_left[c] - 1;
            end
        end
        if (exp_v) m_ptr = (exp_id + 1) % NCTX;
    endfunction

    task automatic compare(input string tag);
        n_cmp++;
        if (grant_valid !== exp_v || (exp_v && int'(grant_ctx) != exp_id)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b ctx=%0d expected valid=%0b ctx=%0d",
                     tag, grant_valid, grant_ctx, exp_v, exp_id);
        end
    endtask

    // caller sets inputs right after a falling edge
    task automatic step(input string tag);
        model_step();
        @(negedge clk);
        compare(tag);
        mem_iss_en  = 1'b0;
        mem_done_en = 1'b0;
    endtask

    task automatic set_ctx(input logic [NCTX-1:0] v, input logic [NCTX-1:0] r);
        ctx_valid = v;
        ctx_ready = r;
    endtask

    task automatic issue(input int c, input int look);
        mem_iss_en   = 1'b1;
        mem_iss_ctx  = IDW'(c);
        mem_iss_look = LA_W'(look);
    endtask

    task automatic finish_op(input int c);
        mem_done_en  = 1'b1;
        mem_done_ctx = IDW'(c);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        summary();
    end

    initial begin
        for (int c = 0; c < NCTX; c++) begin
            m_busy[c] = 1'b0;
            m_left[c] = 0;
        end
        m_ptr  = 0;
        exp_v  = 1'b0;
        exp_id = 0;
        set_ctx('1, '1);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        compare("R1 reset state");
        n_cmp++;
        if (grant_ctx !== '0) begin
            n_bad++;
            $display("FAIL R1: ctx=%0d expected 0", grant_ctx);
        end
        step("R1 first grant lowest");
        step("R2 registered next grant");

        // rotation and wrap: contexts 1, 6, 7 open
        set_ctx(8'b1100_0010, '1);
        for (int i = 0; i < 6; i++) step("R4 rotate wrap");

        // not ready or not valid contexts are passed over
        set_ctx(8'b0011_1100, 8'b0101_0101);
        for (int i = 0; i < 4; i++) step("R3 skip not ready");

        // idle: pointer must hold
        set_ctx('0, '1);
        step("R5 idle no grant");
        step("R5 idle no grant");
        set_ctx('1, '1);
        step("R5 pointer held");

        // lookahead zero
        set_ctx(8'b0000_0100, '1);
        issue(2, 0);
        step("R8 issue look0");
        step("R8 held after look0");
        step("R8 held after look0");
        finish_op(2);
        step("R7 completion cycle");
        step("R7 released");

        // budget of two
        set_ctx(8'b0010_0000, '1);
        issue(5, 2);
        step("R6 load budget");
        step("R6 budget use");
        step("R6 budget use");
        step("R6 budget empty");
        // issue and completion collide on same context: issue wins
        issue(5, 0);
        finish_op(5);
        step("R7 collision issue wins");
        step("R7 collision held");
        finish_op(5);
        step("R7 done");
        step("R7 released again");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            ctx_valid = NCTX'($urandom) | NCTX'($urandom);
            ctx_ready = NCTX'($urandom) | NCTX'($urandom);
            if (($urandom % 4) == 0) issue(int'($urandom % NCTX), int'($urandom % 8));
            if (($urandom % 3) == 0) finish_op(int'($urandom % NCTX));
            step(exp_v ? "R3 random" : "R6 random");
            n_cmp++;
            if (grant_valid && int'(grant_ctx) >= NCTX) begin
                n_bad++;
                $display("FAIL R9: ctx=%0d expected below %0d", grant_ctx, NCTX);
            end
        end
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
    end

endmodule